// File: doc/BRIEF.md
# Eight-Channel Converter Register Front End

This block is the digital side of an eight-channel digital-to-analog converter. A host writes over a simple parallel bus made of a write strobe, a mode pin, a channel address and a 10-bit data word. When the mode pin is low, the write goes to a control register. Bit 0 of the word then picks either the shared system register or the control register of the addressed channel. When the mode pin is high, the write goes to one of the channel's two input code registers, the coarse (main) register or the fine (sub) register.

The input registers are double buffered. A load strobe copies every channel's pair of input registers into the output registers that feed the analog stage. During that same copy the block converts the codes to offset binary when the part is in twos-complement mode, and forces a main code to its clear level when a clear is pending. Per channel, the block also presents a standby flag and a 2-bit bias source select. It presents one global power-down flag.

A data word can arrive in one write or as two partial writes. In two-write mode, bit 0 of each data word steers it to the main or sub register, and a per-channel phase bit tracks which half comes next.

Top module: `octal_dac_front`

## Requirements
- R1: After reset, `pwr_down` is 0, every `stby_o` bit is 1, every bias select is 00, and every main and sub output code is 0.
- R2: A write with `mode_sel`=1 changes only the input register of the channel given by `addr` (000 = first channel, 111 = last). After a load, only that channel's output code changes.
- R3: A write with `mode_sel`=0 and `wdata[0]`=0 loads the system register: bit 1 selects two-write mode, bit 2 selects offset binary (0 = twos complement), bit 3 is power-on (active low power-down), bit 4 is system standby and bit 5 is system clear. A write with `wdata[0]`=1 loads the control register of the addressed channel: bits 2:1 are the bias select, bit 3 is the sub select, bit 4 is run (active low standby) and bit 5 is clear.
- R4: One cycle after a control write, `pwr_down` equals the inverse of the power-on bit. `stby_o[i]` is 1 when system standby is set or channel i's run bit is 0.
- R5: One cycle after a channel control write, that channel's `bias_sel` equals the written bits 2:1.
- R6: The main and sub output codes change only in the cycle after `load`. A load copies all channels at once.
- R7: In single-write mode, a data write goes to the main register when the channel's sub select is 0 and to the sub register when it is 1. All 10 bits are written.
- R8: In two-write mode, `wdata[0]` chooses the register (0 main, 1 sub) regardless of the sub select bit. The first write places `wdata[9:2]` into code bits 7:0. The second write places `wdata[9:8]` into code bits 9:8.
- R9: The two-write phase restarts at the low half whenever a write's {mode, address} differs from the previous write's.
- R10: On load, offset binary codes are passed through unchanged, and twos-complement codes have their MSB inverted.
- R11: With a channel's clear bit set, a load drives that channel's main output to 0x000 under offset binary or 0x200 under twos complement. The sub output loads normally. Nothing changes before the load.
- R12: With the system clear bit set, a load drives every main output to its clear level (as in R11). Every sub output loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| mode_sel | input | 1 | 1 = data write, 0 = control write |
| addr | input | 3 | Channel address |
| wdata | input | 10 | Write data |
| load | input | 1 | Copies input registers to outputs |
| main_code | output | 80 | Main codes, channel i at bits [10i+9:10i] |
| sub_code | output | 80 | Sub codes, same packing |
| stby_o | output | 8 | Per-channel standby |
| bias_sel | output | 16 | Bias select, channel i at bits [2i+1:2i] |
| pwr_down | output | 1 | Global power-down |

## Verification
A wrong control register shows on `stby_o`, `bias_sel` or `pwr_down` one cycle after the write. A wrong input register or steering decision stays hidden until the next load, and then shows as a wrong main or sub code in the following cycle. The bench therefore checks the outputs both before and after each load. A wrong byte phase shows as swapped code halves. A clear or coding fault shows only at a load, as a wrong main level or a disturbed sub code.

// File: rtl/odac_pkg.sv
package odac_pkg;
    localparam int SEL_B     = 0;
    localparam int SYS_FMT_B = 1;
    localparam int SYS_COD_B = 2;
    localparam int SYS_PWR_B = 3;
    localparam int SYS_STB_B = 4;
    localparam int SYS_CLR_B = 5;
    localparam int CH_BIAS_B = 1;
    localparam int CH_SUB_B  = 3;
    localparam int CH_RUN_B  = 4;
    localparam int CH_CLR_B  = 5;
    localparam int BIAS_W    = 2;

    typedef struct packed {
        logic byte_fmt;
        logic offset_bin;
        logic pwr_on;
        logic sys_stby;
        logic sys_clr;
    } sys_ctl_t;

    typedef struct packed {
        logic [BIAS_W-1:0] bias;
        logic              sub_sel;
        logic              run;
        logic              clr;
    } ch_ctl_t;
endpackage

// File: rtl/odac_decode.sv
module odac_decode #(
    parameter int NUM_CH = 8,
    parameter int AW     = 3
) (
    input  logic              wr_en,
    input  logic              mode_sel,
    input  logic [AW-1:0]     addr,
    input  logic              sel_bit,
    output logic              sys_we,
    output logic [NUM_CH-1:0] ctl_we,
    output logic [NUM_CH-1:0] dat_we
);
    assign sys_we = wr_en & ~mode_sel & ~sel_bit;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        logic hit;
        assign hit       = (addr == AW'(i));
        assign ctl_we[i] = wr_en & ~mode_sel & sel_bit & hit;
        assign dat_we[i] = wr_en & mode_sel & hit;
    end
endmodule

// File: rtl/odac_byteseq.sv
module odac_byteseq #(
    parameter int NUM_CH = 8,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              mode_sel,
    input  logic [AW-1:0]     addr,
    input  logic [NUM_CH-1:0] dat_we,
    output logic              hi_half
);
    typedef struct packed {
        logic [AW:0]       last_key;
        logic              last_vld;
        logic [NUM_CH-1:0] half;
    } seq_t;

    seq_t seq_d, seq_q;
    logic restart;

    always_comb begin
        seq_d   = seq_q;
        restart = wr_en && (!seq_q.last_vld || ({mode_sel, addr} != seq_q.last_key));
        hi_half = restart ? 1'b0 : seq_q.half[addr];
        if (wr_en) begin
            seq_d.last_key = {mode_sel, addr};
            seq_d.last_vld = 1'b1;
            if (restart) seq_d.half = '0;
            if (|dat_we) seq_d.half[addr] = ~hi_half;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/odac_chan.sv
module odac_chan
    import odac_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              dat_we,
    input  logic [DW-1:0]     wdata,
    input  logic              byte_fmt,
    input  logic              hi_half,
    input  logic              offset_bin,
    input  logic              sys_clr,
    input  logic              load,
    output logic [DW-1:0]     main_o,
    output logic [DW-1:0]     sub_o,
    output logic              run_o,
    output logic [BIAS_W-1:0] bias_o
);
    localparam int LO_W = DW - 2;

    typedef struct packed {
        ch_ctl_t       ctl;
        logic [DW-1:0] in_main;
        logic [DW-1:0] in_sub;
        logic [DW-1:0] out_main;
        logic [DW-1:0] out_sub;
    } chan_t;

    chan_t st_d, st_q;
    logic          to_sub;
    logic [DW-1:0] upd;

    function automatic logic [DW-1:0] to_offset(input logic [DW-1:0] x, input logic ob);
        return ob ? x : {~x[DW-1], x[DW-2:0]};
    endfunction

    always_comb begin
        st_d   = st_q;
        to_sub = byte_fmt ? wdata[SEL_B] : st_q.ctl.sub_sel;
        upd    = to_sub ? st_q.in_sub : st_q.in_main;
        if (!byte_fmt)    upd            = wdata;
        else if (!hi_half) upd[LO_W-1:0]  = wdata[DW-1:2];
        else              upd[DW-1:LO_W] = wdata[DW-1:LO_W];

        if (ctl_we) begin
            st_d.ctl.bias    = wdata[CH_BIAS_B +: BIAS_W];
            st_d.ctl.sub_sel = wdata[CH_SUB_B];
            st_d.ctl.run     = wdata[CH_RUN_B];
            st_d.ctl.clr     = wdata[CH_CLR_B];
        end
        if (dat_we) begin
            if (to_sub) st_d.in_sub  = upd;
            else        st_d.in_main = upd;
        end
        if (load) begin
            st_d.out_main = to_offset((st_q.ctl.clr | sys_clr) ? '0 : st_q.in_main, offset_bin);
            st_d.out_sub  = to_offset(st_q.in_sub, offset_bin);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.ctl.run <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign main_o = st_q.out_main;
    assign sub_o  = st_q.out_sub;
    assign run_o  = st_q.ctl.run;
    assign bias_o = st_q.ctl.bias;
endmodule

// File: rtl/octal_dac_front.sv
module octal_dac_front
    import odac_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 10,
    localparam int AW    = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     mode_sel,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     load,
    output logic [NUM_CH*DW-1:0]     main_code,
    output logic [NUM_CH*DW-1:0]     sub_code,
    output logic [NUM_CH-1:0]        stby_o,
    output logic [NUM_CH*BIAS_W-1:0] bias_sel,
    output logic                     pwr_down
);
    sys_ctl_t          sys_d, sys_q;
    logic              sys_we, hi_half;
    logic [NUM_CH-1:0] ctl_we, dat_we, run;
    logic              sys_clr_w, coding_ob_w;

    always_comb begin
        sys_d = sys_q;
        if (sys_we) begin
            sys_d.byte_fmt   = wdata[SYS_FMT_B];
            sys_d.offset_bin = wdata[SYS_COD_B];
            sys_d.pwr_on     = wdata[SYS_PWR_B];
            sys_d.sys_stby   = wdata[SYS_STB_B];
            sys_d.sys_clr    = wdata[SYS_CLR_B];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sys_q <= '{byte_fmt: 1'b0, offset_bin: 1'b0, pwr_on: 1'b1,
                               sys_stby: 1'b1, sys_clr: 1'b0};
        else        sys_q <= sys_d;
    end

    assign sys_clr_w   = sys_q.sys_clr;
    assign coding_ob_w = sys_q.offset_bin;
    assign pwr_down    = ~sys_q.pwr_on;

    odac_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
        .wr_en(wr_en), .mode_sel(mode_sel), .addr(addr), .sel_bit(wdata[SEL_B]),
        .sys_we(sys_we), .ctl_we(ctl_we), .dat_we(dat_we)
    );

    odac_byteseq #(.NUM_CH(NUM_CH), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode_sel(mode_sel),
        .addr(addr), .dat_we(dat_we), .hi_half(hi_half)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        odac_chan #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we[i]), .dat_we(dat_we[i]),
            .wdata(wdata), .byte_fmt(sys_q.byte_fmt), .hi_half(hi_half),
            .offset_bin(sys_q.offset_bin), .sys_clr(sys_q.sys_clr), .load(load),
            .main_o(main_code[i*DW +: DW]), .sub_o(sub_code[i*DW +: DW]),
            .run_o(run[i]), .bias_o(bias_sel[i*BIAS_W +: BIAS_W])
        );
        assign stby_o[i] = sys_q.sys_stby | ~run[i];
    end
endmodule

// File: rtl/odac_chk.sv
module odac_chk #(
    parameter int NUM_CH = 8,
    parameter int DW     = 10,
    parameter int AW     = 3,
    parameter int BW     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 mode_sel,
    input logic [AW-1:0]        addr,
    input logic [4:0]           ctl_bits,
    input logic                 load,
    input logic [NUM_CH*DW-1:0] main_code,
    input logic [NUM_CH*DW-1:0] sub_code,
    input logic [NUM_CH-1:0]    stby_o,
    input logic [NUM_CH*BW-1:0] bias_sel,
    input logic                 pwr_down,
    input logic                 sys_clr_w,
    input logic                 coding_ob_w
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(main_code) && $stable(sub_code)));

    p_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_sel && !ctl_bits[0]) |=> (pwr_down == !$past(ctl_bits[3])));

    p_sstb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_sel && !ctl_bits[0] && ctl_bits[4]) |=> (&stby_o));

    p_bias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_sel && ctl_bits[0])
        |=> (bias_sel[int'($past(addr))*BW +: BW] == $past(ctl_bits[2:1])));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
        p_sysclr_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (load && sys_clr_w)
            |=> (main_code[i*DW +: DW] == ($past(coding_ob_w) ? '0 : MID)));
    end
endmodule

bind octal_dac_front odac_chk #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW), .BW(odac_pkg::BIAS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode_sel(mode_sel), .addr(addr),
    .ctl_bits(wdata[4:0]), .load(load), .main_code(main_code), .sub_code(sub_code),
    .stby_o(stby_o), .bias_sel(bias_sel), .pwr_down(pwr_down),
    .sys_clr_w(sys_clr_w), .coding_ob_w(coding_ob_w)
);

// File: tb/octal_dac_front_tb.sv
`timescale 1ns/1ps
module octal_dac_front_tb;
    localparam int N = 8;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst_n, wr_en, mode_sel, load;
    logic [2:0] addr;
    logic [W-1:0] wdata;
    logic [N*W-1:0] main_code, sub_code;
    logic [N-1:0] stby_o;
    logic [N*2-1:0] bias_sel;
    logic pwr_down;

    always #2.5 clk = ~clk;

    octal_dac_front u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode_sel(mode_sel), .addr(addr),
        .wdata(wdata), .load(load), .main_code(main_code), .sub_code(sub_code),
        .stby_o(stby_o), .bias_sel(bias_sel), .pwr_down(pwr_down)
    );

    typedef struct {
        int           ch;
        logic [W-1:0] main_e;
        logic [W-1:0] sub_e;
        string        tag;
    } item_t;

    item_t q[$];
    event  ev_chk;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;

    // model state
    logic m_fmt, m_ob, m_pwrn, m_sstb, m_sclr;
    logic [1:0] m_bias[N];
    logic m_sub[N], m_run[N], m_clr[N], m_half[N];
    logic [W-1:0] m_in_main[N], m_in_sub[N], m_out_main[N], m_out_sub[N];
    logic [3:0] m_key;
    logic m_vld;

    task automatic cmp(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk_sys(logic clr, logic stb, logic pwrn, logic ob, logic fmt);
        return {4'b0, clr, stb, pwrn, ob, fmt, 1'b0};
    endfunction

    function automatic logic [W-1:0] mk_ch(logic clr, logic run, logic sub, logic [1:0] b);
        return {4'b0, clr, run, sub, b, 1'b1};
    endfunction

    function automatic logic [W-1:0] conv(logic [W-1:0] x);
        return m_ob ? x : {~x[W-1], x[W-2:0]};
    endfunction

    task automatic wr(logic md, logic [2:0] a, logic [W-1:0] d);
        logic restart, hi, tosub;
        logic [W-1:0] v;
        restart = !m_vld || ({md, a} != m_key);
        hi = restart ? 1'b0 : m_half[a];
        if (restart) for (int k = 0; k < N; k++) m_half[k] = 1'b0;
        m_key = {md, a};
        m_vld = 1'b1;
        if (md) begin
            tosub = m_fmt ? d[0] : m_sub[a];
            v = tosub ? m_in_sub[a] : m_in_main[a];
            if (!m_fmt)  v = d;
            else if (!hi) v[7:0] = d[9:2];
            else         v[9:8] = d[9:8];
            if (tosub) m_in_sub[a] = v; else m_in_main[a] = v;
            m_half[a] = !hi;
        end else if (!d[0]) begin
            m_fmt = d[1]; m_ob = d[2]; m_pwrn = d[3]; m_sstb = d[4]; m_sclr = d[5];
        end else begin
            m_bias[a] = d[2:1]; m_sub[a] = d[3]; m_run[a] = d[4]; m_clr[a] = d[5];
        end
        @(negedge clk);
        wr_en = 1'b1; mode_sel = md; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: model load, push expectations, pulse load, wake the monitor
    task automatic ld(string tag);
        for (int i = 0; i < N; i++) begin
            item_t it;
            m_out_main[i] = conv((m_clr[i] || m_sclr) ? '0 : m_in_main[i]);
            m_out_sub[i]  = conv(m_in_sub[i]);
            it.ch = i; it.main_e = m_out_main[i]; it.sub_e = m_out_sub[i]; it.tag = tag;
            q.push_back(it);
        end
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        -> ev_chk;
        #1;
    endtask

    // monitor
    initial begin
        forever begin
            @(ev_chk);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                cmp({it.tag, " main"}, int'(main_code[it.ch*W +: W]), int'(it.main_e));
                cmp({it.tag, " sub"},  int'(sub_code[it.ch*W +: W]),  int'(it.sub_e));
            end
        end
    end

    task automatic chk_ctl(string tag);
        cmp({tag, " pwr_down"}, int'(pwr_down), int'(!m_pwrn));
        for (int i = 0; i < N; i++) begin
            cmp({tag, " stby"}, int'(stby_o[i]), int'(m_sstb || !m_run[i]));
            cmp({tag, " bias"}, int'(bias_sel[i*2 +: 2]), int'(m_bias[i]));
        end
    endtask

    task automatic chk_out(string tag);
        for (int i = 0; i < N; i++) begin
            cmp({tag, " main"}, int'(main_code[i*W +: W]), int'(m_out_main[i]));
            cmp({tag, " sub"},  int'(sub_code[i*W +: W]),  int'(m_out_sub[i]));
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        m_fmt = 0; m_ob = 0; m_pwrn = 1; m_sstb = 1; m_sclr = 0; m_key = '0; m_vld = 0;
        for (int i = 0; i < N; i++) begin
            m_bias[i] = 0; m_sub[i] = 0; m_run[i] = 1; m_clr[i] = 0; m_half[i] = 0;
            m_in_main[i] = 0; m_in_sub[i] = 0; m_out_main[i] = 0; m_out_sub[i] = 0;
        end
        rst_n = 0; wr_en = 0; mode_sel = 0; addr = 0; wdata = 0; load = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_ctl("R1 reset");
        chk_out("R1 reset");

        wr(0, 3'd0, mk_sys(0, 0, 1, 1, 0));
        chk_ctl("R3 R4 system write");
        for (int i = 0; i < N; i++) wr(0, 3'(i), mk_ch(0, 1, 0, 2'(i)));
        chk_ctl("R3 R5 channel bias");

        for (int i = 0; i < N; i++) wr(1, 3'(i), 10'(64 + i * 71));
        chk_out("R6 held before load");
        ld("R2 decode");

        wr(0, 3'd3, mk_ch(0, 1, 1, 2'd3));
        wr(1, 3'd3, 10'h2AB);
        chk_out("R6 held before load");
        ld("R7 sub steer");
        wr(0, 3'd3, mk_ch(0, 1, 0, 2'd3));
        wr(1, 3'd3, 10'h155);
        ld("R7 main steer");

        wr(0, 3'd0, mk_sys(0, 0, 1, 0, 0));
        ld("R10 twos complement");

        wr(0, 3'd5, mk_ch(0, 0, 0, 2'd1));
        chk_ctl("R4 channel standby");
        wr(0, 3'd0, mk_sys(0, 0, 0, 0, 0));
        chk_ctl("R4 power down");
        wr(0, 3'd0, mk_sys(0, 1, 1, 0, 0));
        chk_ctl("R4 system standby");
        wr(0, 3'd0, mk_sys(0, 0, 1, 0, 0));

        wr(0, 3'd2, mk_ch(1, 1, 0, 2'd2));
        chk_out("R11 clear waits for load");
        ld("R11 clear twos");
        wr(0, 3'd0, mk_sys(0, 0, 1, 1, 0));
        ld("R11 clear offset");
        wr(0, 3'd2, mk_ch(0, 1, 0, 2'd2));
        ld("R11 clear released");

        wr(0, 3'd0, mk_sys(1, 0, 1, 1, 0));
        ld("R12 system clear offset");
        wr(0, 3'd0, mk_sys(1, 0, 1, 0, 0));
        ld("R12 system clear twos");
        wr(0, 3'd0, mk_sys(0, 0, 1, 1, 0));
        ld("R12 system clear released");

        wr(0, 3'd0, mk_sys(0, 0, 1, 1, 1));
        wr(1, 3'd6, {8'hA5, 2'b00});
        wr(1, 3'd6, {2'b11, 8'h00});
        wr(1, 3'd6, {8'h3C, 2'b01});
        wr(1, 3'd6, {2'b01, 8'h01});
        ld("R8 byte main and sub");
        wr(0, 3'd3, mk_ch(0, 1, 1, 2'd3));
        wr(1, 3'd3, {8'h0F, 2'b00});
        wr(1, 3'd3, {2'b10, 8'h00});
        ld("R8 bit0 overrides select");

        wr(1, 3'd1, {8'h11, 2'b00});
        wr(1, 3'd2, {8'h22, 2'b00});
        wr(1, 3'd1, {8'h77, 2'b00});
        wr(1, 3'd1, {2'b01, 8'h00});
        ld("R9 restart on address");
        wr(1, 3'd4, {8'h44, 2'b00});
        wr(0, 3'd4, mk_ch(0, 1, 0, 2'd0));
        wr(1, 3'd4, {8'h99, 2'b00});
        wr(1, 3'd4, {2'b10, 8'h00});
        ld("R9 restart on mode");
        chk_ctl("R5 final control");

        done = 1;
        summary();
        $finish;
    end
endmodule